// File: doc/BRIEF.md
# ALU Execute Stage with Operand Recirculation

This block is the execute slice of a four-stage processor pipeline. The decode stage selects the operands, and on a load cycle they are captured in three operand registers: A, B, and a one-bit carry input C. The ALU then has the whole next cycle to itself. Its output, the data result together with the carry out, is captured in a result register R. Operand setup therefore never shares a cycle with the arithmetic.

Each of the A and B operand muxes can take one of four sources: the register-file bus, the value held in R (recirculation), fresh memory read data, or zero. The carry input can come from an external carry line or from the carry bit held in R. With these paths, a multi-byte sum such as a 16-bit address calculation runs without a trip through the register file. The block also holds the values presented to memory. Two address registers, a low byte and a high byte, load from R or from memory read data. A write strobe register and a write data register hold a pending store.

Top module: `alu_exec_stage`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `r_result`, `r_carry`, `r_valid`, `adl`, `adh`, `mem_we` and `mem_wdata` are all zero.
- R2: An operand load requested with `opnd_load` high in cycle N produces its result on `r_result`/`r_carry` after the rising edge that ends cycle N+1. `r_valid` is high for exactly one cycle in that case, and it is low after any cycle N with no load.
- R3: The `a_sel`/`b_sel` codes pick the operand source: 2'b00 selects `rf_bus`, 2'b01 selects the current `r_result`, 2'b10 selects `mem_rdata`, and 2'b11 selects zero. `c_sel` = 0 takes `cin_bus` as the carry input, and `c_sel` = 1 takes the current `r_carry`.
- R4: `op_code` 3'd0 (add) yields the low DW bits of A+B+C, with the carry out as bit DW of that sum. `op_code` 3'd1 (subtract) yields A+~B+C in the same way, so C=1 means no borrow.
- R5: `op_code` 3'd2 (AND), 3'd3 (OR) and 3'd4 (XOR) yield the bitwise result with the carry out 0.
- R6: `op_code` 3'd5 (shift left) yields {A[DW-2:0],C} with carry out A[DW-1]. `op_code` 3'd6 (shift right) yields {C,A[DW-1:1]} with carry out A[0].
- R7: `op_code` 3'd7 is reserved and yields a zero result and a zero carry.
- R8: R keeps its value, result and carry alike, in every cycle that follows a cycle with no operand load.
- R9: `adl` and `adh` each load on the edge after their load strobe is high: from `r_result` when their select is 0 and from `mem_rdata` when it is 1. Otherwise they hold their value.
- R10: `mem_we` is the value `wr_req` had in the previous cycle. `mem_wdata` loads `r_result` (`dor_sel` = 0) or `rf_bus` (`dor_sel` = 1) on the edge after `wr_req` is high, and holds its value otherwise.
- R11: A low-byte add, followed by a high-byte add that takes its carry from R, leaves the full 2*DW-bit sum in {`adh`,`adl`} once both bytes have been loaded from R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| opnd_load | input | 1 | Capture operands and operation this cycle |
| a_sel | input | 2 | A operand source select |
| b_sel | input | 2 | B operand source select |
| c_sel | input | 1 | Carry input source select |
| op_code | input | 3 | ALU operation |
| rf_bus | input | DW | Register-file bus |
| mem_rdata | input | DW | Memory read data |
| cin_bus | input | 1 | External carry input |
| adl_load | input | 1 | Load the low address register |
| adl_sel | input | 1 | Low address source: 0 R, 1 memory data |
| adh_load | input | 1 | Load the high address register |
| adh_sel | input | 1 | High address source: 0 R, 1 memory data |
| wr_req | input | 1 | Request a memory write |
| dor_sel | input | 1 | Write data source: 0 R, 1 register-file bus |
| r_result | output | DW | Result register |
| r_carry | output | 1 | Carry out held in R |
| r_valid | output | 1 | R was updated on the last edge |
| adl | output | DW | Low address byte |
| adh | output | DW | High address byte |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |

## Verification
The assertions check on every cycle the structural rules: the two-edge valid latency, R holding between loads, the zero-carry rule for logic operations, the reserved code, the zero operand source, the address registers holding and the strobe following its request. They cannot show that the arithmetic is correct, so the bench sweeps every operation over all operand and carry combinations at a narrow data width. The bench also runs each source select and the two-byte address sum with the carry recirculated, which only a sequence of scenarios can exercise.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_R    = 2'b01,
    SRC_MEM  = 2'b10,
    SRC_ZERO = 2'b11
  } opnd_src_e;

  localparam int unsigned NUM_MUXED_OPND = 2;

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
  import alu_exec_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] rf_bus,
  input  logic [DW-1:0] r_fb,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] opnd
);

  opnd_src_e src;

  always_comb begin
    src = opnd_src_e'(sel);
    unique case (src)
      SRC_RF:   opnd = rf_bus;
      SRC_R:    opnd = r_fb;
      SRC_MEM:  opnd = mem_rdata;
      default:  opnd = '0;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_exec_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c,
  output logic [DW-1:0] res,
  output logic          co
);

  localparam int unsigned SW = DW + 1;

  logic [SW-1:0] add_sum;
  logic [SW-1:0] sub_sum;
  logic [DW-1:0] b_inv;

  always_comb begin
    b_inv   = ~b;
    add_sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
    sub_sum = {1'b0, a} + {1'b0, b_inv} + {{DW{1'b0}}, c};
  end

  always_comb begin
    res = '0;
    co  = 1'b0;
    unique case (op)
      OP_ADD: begin
        res = add_sum[DW-1:0];
        co  = add_sum[DW];
      end
      OP_SUB: begin
        res = sub_sum[DW-1:0];
        co  = sub_sum[DW];
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHL: begin
        res = {a[DW-2:0], c};
        co  = a[DW-1];
      end
      OP_SHR: begin
        res = {c, a[DW-1:1]};
        co  = a[0];
      end
      default: begin
        res = '0;
        co  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_mem_port.sv
module alu_mem_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adl_load,
  input  logic          adl_sel,
  input  logic          adh_load,
  input  logic          adh_sel,
  input  logic          wr_req,
  input  logic          dor_sel,
  input  logic [DW-1:0] r_res,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] rf_bus,
  output logic [DW-1:0] adl,
  output logic [DW-1:0] adh,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata
);

  logic [DW-1:0] adl_q, adl_d;
  logic [DW-1:0] adh_q, adh_d;
  logic [DW-1:0] dor_q, dor_d;
  logic          we_q, we_d;

  always_comb begin
    adl_d = adl_q;
    if (adl_load) adl_d = adl_sel ? mem_rdata : r_res;
    adh_d = adh_q;
    if (adh_load) adh_d = adh_sel ? mem_rdata : r_res;
    dor_d = dor_q;
    if (wr_req) dor_d = dor_sel ? rf_bus : r_res;
    we_d = wr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adl_q <= '0;
      adh_q <= '0;
      dor_q <= '0;
      we_q  <= 1'b0;
    end else begin
      adl_q <= adl_d;
      adh_q <= adh_d;
      dor_q <= dor_d;
      we_q  <= we_d;
    end
  end

  assign adl       = adl_q;
  assign adh       = adh_q;
  assign mem_we    = we_q;
  assign mem_wdata = dor_q;

  AST_ADL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adl_load |=> $stable(adl)); // R9
  AST_ADH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adh_load |=> $stable(adh)); // R9
  AST_WE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> mem_we); // R10
  AST_WE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !mem_we); // R10
  AST_DOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(mem_wdata)); // R10

endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
  import alu_exec_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opnd_load,
  input  logic [1:0]    a_sel,
  input  logic [1:0]    b_sel,
  input  logic          c_sel,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] rf_bus,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cin_bus,
  input  logic          adl_load,
  input  logic          adl_sel,
  input  logic          adh_load,
  input  logic          adh_sel,
  input  logic          wr_req,
  input  logic          dor_sel,
  output logic [DW-1:0] r_result,
  output logic          r_carry,
  output logic          r_valid,
  output logic [DW-1:0] adl,
  output logic [DW-1:0] adh,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // operand registers
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] b_q, b_d;
  logic          c_q, c_d;
  alu_op_e       op_q, op_d;
  logic          exe_vld_q, exe_vld_d;

  // result register
  logic [DW-1:0] r_q, r_d;
  logic          rc_q, rc_d;
  logic          rv_q, rv_d;

  logic [NUM_MUXED_OPND-1:0][1:0]    mux_sel;
  logic [NUM_MUXED_OPND-1:0][DW-1:0] mux_out;
  logic          c_src;
  logic [DW-1:0] alu_res;
  logic          alu_co;

  assign mux_sel = {b_sel, a_sel};

  for (genvar gi = 0; gi < NUM_MUXED_OPND; gi++) begin : g_opnd_mux
    alu_operand_mux #(.DW(DW)) u_mux (
      .sel       (mux_sel[gi]),
      .rf_bus    (rf_bus),
      .r_fb      (r_q),
      .mem_rdata (mem_rdata),
      .opnd      (mux_out[gi])
    );
  end

  assign c_src = c_sel ? rc_q : cin_bus;

  always_comb begin
    a_d       = a_q;
    b_d       = b_q;
    c_d       = c_q;
    op_d      = op_q;
    exe_vld_d = opnd_load;
    if (opnd_load) begin
      a_d  = mux_out[0];
      b_d  = mux_out[1];
      c_d  = c_src;
      op_d = alu_op_e'(op_code);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_q       <= '0;
      b_q       <= '0;
      c_q       <= 1'b0;
      op_q      <= OP_ADD;
      exe_vld_q <= 1'b0;
    end else begin
      a_q       <= a_d;
      b_q       <= b_d;
      c_q       <= c_d;
      op_q      <= op_d;
      exe_vld_q <= exe_vld_d;
    end
  end

  alu_core #(.DW(DW)) u_core (
    .op  (op_q),
    .a   (a_q),
    .b   (b_q),
    .c   (c_q),
    .res (alu_res),
    .co  (alu_co)
  );

  always_comb begin
    r_d  = r_q;
    rc_d = rc_q;
    rv_d = exe_vld_q;
    if (exe_vld_q) begin
      r_d  = alu_res;
      rc_d = alu_co;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      r_q  <= '0;
      rc_q <= 1'b0;
      rv_q <= 1'b0;
    end else begin
      r_q  <= r_d;
      rc_q <= rc_d;
      rv_q <= rv_d;
    end
  end

  assign r_result = r_q;
  assign r_carry  = rc_q;
  assign r_valid  = rv_q;

  alu_mem_port #(.DW(DW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_q),
    .adl_load  (adl_load),
    .adl_sel   (adl_sel),
    .adh_load  (adh_load),
    .adh_sel   (adh_sel),
    .wr_req    (wr_req),
    .dor_sel   (dor_sel),
    .r_res     (r_q),
    .mem_rdata (mem_rdata),
    .rf_bus    (rf_bus),
    .adl       (adl),
    .adh       (adh),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_q)
    opnd_load |=> ##1 r_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_q)
    !opnd_load |=> ##1 !r_valid); // R2
  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_q)
    (opnd_load && a_sel == 2'b11 && b_sel == 2'b11) |=> (a_q == '0 && b_q == '0)); // R3
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_q)
    (exe_vld_q && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR)) |=> !r_carry); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (exe_vld_q && op_q == OP_RSVD) |=> (r_result == '0 && !r_carry)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !exe_vld_q |=> ($stable(r_result) && $stable(r_carry))); // R8

endmodule

// File: tb/alu_exec_stage_test.sv
module alu_exec_stage_test;

  localparam int unsigned DW      = 4;
  localparam int unsigned MASK    = (1 << DW) - 1;
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          opnd_load, c_sel, cin_bus;
  logic [1:0]    a_sel, b_sel;
  logic [2:0]    op_code;
  logic [DW-1:0] rf_bus, mem_rdata;
  logic          adl_load, adl_sel, adh_load, adh_sel, wr_req, dor_sel;
  logic [DW-1:0] r_result, adl, adh, mem_wdata;
  logic          r_carry, r_valid, mem_we;

  int tests = 0;
  int fails = 0;

  always #(CLK_PER/2) clk = ~clk;

  alu_exec_stage #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .opnd_load(opnd_load), .a_sel(a_sel), .b_sel(b_sel),
    .c_sel(c_sel), .op_code(op_code), .rf_bus(rf_bus), .mem_rdata(mem_rdata),
    .cin_bus(cin_bus), .adl_load(adl_load), .adl_sel(adl_sel), .adh_load(adh_load),
    .adh_sel(adh_sel), .wr_req(wr_req), .dor_sel(dor_sel), .r_result(r_result),
    .r_carry(r_carry), .r_valid(r_valid), .adl(adl), .adh(adh), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    opnd_load = 0; adl_load = 0; adh_load = 0; wr_req = 0;
  endtask

  function automatic int model(input int op, input int a, input int b, input int c);
    int s;
    case (op)
      0: s = a + b + c;
      1: s = a + ((~b) & MASK) + c;
      2: s = a & b;
      3: s = a | b;
      4: s = a ^ b;
      5: s = ((a << 1) | c) | (((a >> (DW-1)) & 1) << DW);
      6: s = ((c << (DW-1)) | (a >> 1)) | ((a & 1) << DW);
      default: s = 0;
    endcase
    return s & ((MASK << 1) | 1);
  endfunction

  // drive at negedge, result observed two negedges later
  task automatic run_op(input int op, input int a, input int b, input int c,
                        input logic [1:0] as, input logic [1:0] bs, input logic cs);
    op_code = op[2:0]; rf_bus = a[DW-1:0]; mem_rdata = b[DW-1:0]; cin_bus = c[0];
    a_sel = as; b_sel = bs; c_sel = cs; opnd_load = 1;
    @(negedge clk);
    opnd_load = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PER * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int exp, sum, prev;
    rst_n = 0; idle(); a_sel = 0; b_sel = 0; c_sel = 0; op_code = 0;
    rf_bus = 0; mem_rdata = 0; cin_bus = 0; adl_sel = 0; adh_sel = 0; dor_sel = 0;
    repeat (3) @(negedge clk);
    chk(r_result == 0 && !r_carry && !r_valid, "R1 result in reset", int'(r_result), 0);
    chk(adl == 0 && adh == 0 && !mem_we && mem_wdata == 0, "R1 mem regs in reset", int'({adh, adl}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(r_result == 0 && !r_carry && !r_valid, "R1 after release", int'(r_result), 0);
    chk(adl == 0 && adh == 0 && !mem_we && mem_wdata == 0, "R1 mem after release", int'({adh, adl}), 0);

    // exhaustive sweep: all ops, operands and carry
    for (int op = 0; op < 8; op++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          for (int c = 0; c < 2; c++) begin
            run_op(op, a, b, c, 2'b00, 2'b10, 1'b0);
            exp = model(op, a, b, c);
            if (op < 2)      chk(int'({r_carry, r_result}) == exp && r_valid, "R4 add/sub", int'({r_carry, r_result}), exp);
            else if (op < 5) chk(int'({r_carry, r_result}) == exp && r_valid, "R5 logic", int'({r_carry, r_result}), exp);
            else if (op < 7) chk(int'({r_carry, r_result}) == exp && r_valid, "R6 shift", int'({r_carry, r_result}), exp);
            else             chk(int'({r_carry, r_result}) == 0 && r_valid, "R7 reserved", int'({r_carry, r_result}), 0);
          end

    // R2: latency and single-cycle valid
    op_code = 0; rf_bus = 4'h3; mem_rdata = 4'h4; cin_bus = 0;
    a_sel = 2'b00; b_sel = 2'b10; c_sel = 0; opnd_load = 1;
    @(negedge clk); opnd_load = 0;
    chk(!r_valid && r_result != 4'h7, "R2 not yet after one edge", int'(r_result), 0);
    @(negedge clk);
    chk(r_valid && r_result == 4'h7, "R2 after two edges", int'(r_result), 7);
    @(negedge clk);
    chk(!r_valid, "R2 valid one cycle", int'(r_valid), 0);

    // R8: hold while inputs wiggle without load
    prev = int'({r_carry, r_result});
    for (int k = 0; k < 4; k++) begin
      rf_bus = k[DW-1:0] + 4'h9; mem_rdata = 4'hF; op_code = 3'(k); cin_bus = k[0];
      @(negedge clk);
      chk(int'({r_carry, r_result}) == prev && !r_valid, "R8 hold", int'({r_carry, r_result}), prev);
    end

    // R3: R source, zero source, carry from R
    run_op(0, 4'h9, 4'h0, 0, 2'b00, 2'b11, 1'b0);          // R = 9
    run_op(0, 4'h0, 4'h2, 0, 2'b01, 2'b10, 1'b0);          // 9 + 2
    chk(r_result == 4'hB, "R3 a_sel R", int'(r_result), 'hB);
    run_op(0, 4'h1, 4'h0, 0, 2'b00, 2'b01, 1'b0);          // 1 + 11
    chk(r_result == 4'hC, "R3 b_sel R", int'(r_result), 'hC);
    run_op(0, 4'h7, 4'h5, 1, 2'b11, 2'b11, 1'b0);          // 0+0+1
    chk(r_result == 4'h1 && !r_carry, "R3 zero sources", int'(r_result), 1);
    run_op(0, 4'hF, 4'h1, 0, 2'b00, 2'b10, 1'b0);          // carry 1
    run_op(0, 4'h2, 4'h0, 0, 2'b00, 2'b11, 1'b1);          // 2+0+carry
    chk(r_result == 4'h3, "R3 c_sel R carry", int'(r_result), 3);
    run_op(0, 4'h2, 4'h3, 1, 2'b10, 2'b00, 1'b0);          // a=mem3, b=rf2, c=1
    chk(r_result == 4'h6, "R3 swapped sources", int'(r_result), 6);

    // R9: address from memory data, then hold
    mem_rdata = 4'hA; adl_sel = 1; adl_load = 1; adh_sel = 1; adh_load = 1;
    @(negedge clk); idle();
    chk(adl == 4'hA && adh == 4'hA, "R9 load from mem", int'({adh, adl}), 'hAA);
    mem_rdata = 4'h5;
    @(negedge clk);
    chk(adl == 4'hA && adh == 4'hA, "R9 hold", int'({adh, adl}), 'hAA);
    adh_sel = 0; adh_load = 1;
    @(negedge clk); idle();
    chk(adh == r_result && adl == 4'hA, "R9 adh from R", int'(adh), int'(r_result));

    // R10: write strobe and data
    rf_bus = 4'hD; dor_sel = 1; wr_req = 1;
    @(negedge clk); idle();
    chk(mem_we && mem_wdata == 4'hD, "R10 write rf", int'(mem_wdata), 'hD);
    rf_bus = 4'h1;
    @(negedge clk);
    chk(!mem_we && mem_wdata == 4'hD, "R10 hold", int'(mem_wdata), 'hD);
    dor_sel = 0; wr_req = 1;
    @(negedge clk); idle();
    chk(mem_we && mem_wdata == r_result, "R10 write R", int'(mem_wdata), int'(r_result));

    // R11: two-byte address sums with recirculated carry
    for (int base = 0; base < 256; base += 7)
      for (int off = 0; off < 256; off += 13) begin
        sum = (base + off) & 8'hFF;
        run_op(0, base & MASK, off & MASK, 0, 2'b00, 2'b10, 1'b0);
        adl_sel = 0; adl_load = 1;
        op_code = 0; rf_bus = 4'((base >> DW) & MASK); mem_rdata = 4'((off >> DW) & MASK);
        a_sel = 2'b00; b_sel = 2'b10; c_sel = 1; opnd_load = 1;
        @(negedge clk); idle();
        @(negedge clk);
        adh_sel = 0; adh_load = 1;
        @(negedge clk); idle();
        chk(int'({adh, adl}) == sum, "R11 address sum", int'({adh, adl}), sum);
      end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule